// File: doc/BRIEF.md
# Doorbell Dispatch Router with Pending Replay

The router turns doorbell writes into typed dispatch events. Each doorbell write carries a 64-bit value to a doorbell offset. Software first binds an offset to a queue class and an engine index through a registration port. A write to a bound offset then produces one dispatch event, one cycle later. The event names the queue class, the engine, the offset and the value, shaped for that class.

A write to an offset that has no binding is never stalled and never lost while there is room. It is parked in a small pending store. After software binds that offset, it can ask for a replay. The parked value then goes through the normal dispatch path and its slot is released. A bulk command removes every binding in the user-queue region. Bindings below that boundary stay in place.

Top module: `doorbell_router`

## Requirements
- R1: After reset, `disp_valid_o`, `aql_idx_valid_o`, `err_o` and `pend_ovf_o` are low and `wr_ready_o` is high.
- R2: A write accepted to a bound offset raises `disp_valid_o` for one cycle in the following cycle. The event carries the bound class and engine, the offset and the value. The class codes are 3 bits: compute 0, graphics 1, DMA ring 2, DMA page 3, AQL 4, interrupt read pointer 5, run list 6.
- R3: For class 5 the dispatched value is the low 32 bits of the written value, zero-extended to 64 bits.
- R4: For class 4 the dispatched value is the written value plus one, modulo 2^64. The same value appears on `aql_idx_o`, with `aql_idx_valid_o` high in the same cycle as `disp_valid_o`.
- R5: Registering an offset that is already bound replaces its class and engine. Later writes use the new binding.
- R6: A write to an unbound offset is accepted without stall and produces no dispatch. Its offset and value are kept in the pending store. A second such write to the same offset replaces the kept value.
- R7: A replay request for a parked offset that is now bound dispatches the kept value, one cycle later, exactly as a fresh write would. The entry is then freed, so a second replay produces nothing. A replay for an offset with no parked entry produces nothing.
- R8: In any cycle with `replay_valid_i` high, `wr_ready_o` is low and the incoming write is not taken. The write is taken in the first cycle without a replay.
- R9: `clear_user_i` removes every binding whose offset is 0x4000 or above. Bindings at 0x3FFF or below are kept.
- R10: A write that hits a binding of class 7 pulses `err_o` in the following cycle and produces no dispatch.
- R11: The pending store holds 8 entries. A write of a new offset that finds the store full is discarded, and it sets `pend_ovf_o`. The flag stays high until reset.
- R12: The binding table holds 16 entries. A registration of a new offset while all 16 entries are in use is ignored.
- R13: A replay request for a parked offset that is still unbound produces nothing and keeps the parked entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_valid_i | input | 1 | Bind an offset this cycle |
| reg_offset_i | input | 16 | Offset to bind |
| reg_type_i | input | 3 | Queue class code |
| reg_engine_i | input | 4 | Engine index |
| clear_user_i | input | 1 | Remove bindings at or above the user boundary |
| wr_valid_i | input | 1 | Doorbell write present |
| wr_offset_i | input | 16 | Doorbell offset |
| wr_data_i | input | 64 | Doorbell value |
| wr_ready_o | output | 1 | Write taken this cycle when valid |
| replay_valid_i | input | 1 | Replay request |
| replay_offset_i | input | 16 | Offset to replay |
| disp_valid_o | output | 1 | Dispatch event |
| disp_type_o | output | 3 | Queue class of event |
| disp_engine_o | output | 4 | Engine of event |
| disp_offset_o | output | 16 | Offset of event |
| disp_data_o | output | 64 | Shaped value of event |
| aql_idx_valid_o | output | 1 | Read-index update for class 4 |
| aql_idx_o | output | 64 | Read-index value |
| err_o | output | 1 | Hit on an undefined class |
| pend_ovf_o | output | 1 | Sticky pending overflow |

## Verification
The assertions check on every cycle that an interrupt event carries no upper bits and that a read-index update comes with an AQL dispatch of equal value. They also check that an error pulse and a dispatch never coincide, that the overflow flag is sticky, that lookups match at most one entry, and that a clear leaves no user binding behind. The ordering effects can only be seen in the bench's scenarios: a parked value that outlives a first replay, the replacement of a parked value, a write held back by a replay, the exact 0x3FFF/0x4000 boundary, and discards at full capacity.

// File: rtl/db_pkg.sv
package db_pkg;
  typedef enum logic [2:0] {
    QT_COMPUTE  = 3'd0,
    QT_GFX      = 3'd1,
    QT_DMA_RING = 3'd2,
    QT_DMA_PAGE = 3'd3,
    QT_AQL      = 3'd4,
    QT_IRQ      = 3'd5,
    QT_RUNLIST  = 3'd6,
    QT_BAD      = 3'd7
  } qtype_e;
endpackage

// File: rtl/db_table.sv
module db_table #(
  parameter int N         = 16,
  parameter int OFS_W     = 16,
  parameter int ENG_W     = 4,
  parameter int unsigned USER_BASE = 32'h4000
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             reg_i,
  input  logic [OFS_W-1:0] reg_ofs_i,
  input  logic [2:0]       reg_type_i,
  input  logic [ENG_W-1:0] reg_eng_i,
  input  logic             clear_i,
  input  logic [OFS_W-1:0] look_ofs_i,
  output logic             hit_o,
  output logic [2:0]       type_o,
  output logic [ENG_W-1:0] eng_o
);
  localparam int IW = (N > 1) ? $clog2(N) : 1;

  logic [N-1:0]     vld_q;
  logic [OFS_W-1:0] ofs_q [N];
  logic [2:0]       ty_q  [N];
  logic [ENG_W-1:0] eng_q [N];
  logic [N-1:0]     look_m, reg_m, user_m;
  logic [IW-1:0]    slot;
  logic             slot_ok;

  always_comb begin
    hit_o  = 1'b0;
    type_o = '0;
    eng_o  = '0;
    for (int i = 0; i < N; i++) begin
      look_m[i] = vld_q[i] && (ofs_q[i] == look_ofs_i);
      reg_m[i]  = vld_q[i] && (ofs_q[i] == reg_ofs_i);
      user_m[i] = vld_q[i] && (32'(ofs_q[i]) >= USER_BASE);
      if (look_m[i]) begin
        hit_o  = 1'b1;
        type_o = type_o | ty_q[i];
        eng_o  = eng_o | eng_q[i];
      end
    end
  end

  // existing binding wins over first free slot
  always_comb begin
    slot    = '0;
    slot_ok = 1'b0;
    for (int i = 0; i < N; i++)
      if (!slot_ok && !vld_q[i]) begin
        slot    = IW'(i);
        slot_ok = 1'b1;
      end
    for (int i = 0; i < N; i++)
      if (reg_m[i]) begin
        slot    = IW'(i);
        slot_ok = 1'b1;
      end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q <= '0;
      for (int i = 0; i < N; i++) begin
        ofs_q[i] <= '0;
        ty_q[i]  <= '0;
        eng_q[i] <= '0;
      end
    end else begin
      if (clear_i)
        for (int i = 0; i < N; i++)
          if (user_m[i]) vld_q[i] <= 1'b0;
      if (reg_i && slot_ok) begin
        vld_q[slot] <= 1'b1;
        ofs_q[slot] <= reg_ofs_i;
        ty_q[slot]  <= reg_type_i;
        eng_q[slot] <= reg_eng_i;
      end
    end
  end

  p_hit_unique_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(look_m));
  p_clear_user_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i && !reg_i |=> user_m == '0);
endmodule

// File: rtl/db_pend.sv
module db_pend #(
  parameter int N     = 8,
  parameter int OFS_W = 16,
  parameter int DW    = 64
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             store_i,
  input  logic [OFS_W-1:0] store_ofs_i,
  input  logic [DW-1:0]    store_data_i,
  input  logic [OFS_W-1:0] look_ofs_i,
  input  logic             free_i,
  output logic             hit_o,
  output logic [DW-1:0]    data_o,
  output logic             ovf_o
);
  localparam int IW = (N > 1) ? $clog2(N) : 1;

  logic [N-1:0]     vld_q;
  logic [OFS_W-1:0] ofs_q [N];
  logic [DW-1:0]    dat_q [N];
  logic [N-1:0]     look_m, st_m;
  logic [IW-1:0]    slot;
  logic             slot_ok, ovf_q, full;

  assign full  = &vld_q;
  assign ovf_o = ovf_q;

  always_comb begin
    hit_o  = 1'b0;
    data_o = '0;
    for (int i = 0; i < N; i++) begin
      look_m[i] = vld_q[i] && (ofs_q[i] == look_ofs_i);
      st_m[i]   = vld_q[i] && (ofs_q[i] == store_ofs_i);
      if (look_m[i]) begin
        hit_o  = 1'b1;
        data_o = data_o | dat_q[i];
      end
    end
  end

  always_comb begin
    slot    = '0;
    slot_ok = 1'b0;
    for (int i = 0; i < N; i++)
      if (!slot_ok && !vld_q[i]) begin
        slot    = IW'(i);
        slot_ok = 1'b1;
      end
    for (int i = 0; i < N; i++)
      if (st_m[i]) begin
        slot    = IW'(i);
        slot_ok = 1'b1;
      end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q <= '0;
      ovf_q <= 1'b0;
      for (int i = 0; i < N; i++) begin
        ofs_q[i] <= '0;
        dat_q[i] <= '0;
      end
    end else begin
      if (free_i)
        for (int i = 0; i < N; i++)
          if (look_m[i]) vld_q[i] <= 1'b0;
      if (store_i) begin
        if (slot_ok) begin
          vld_q[slot] <= 1'b1;
          ofs_q[slot] <= store_ofs_i;
          dat_q[slot] <= store_data_i;
        end else begin
          ovf_q <= 1'b1;
        end
      end
    end
  end

  p_pend_unique_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(look_m));
  p_full_drop_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    store_i && full && (st_m == '0) |=> ovf_o);
endmodule

// File: rtl/doorbell_router.sv
module doorbell_router
  import db_pkg::*;
#(
  parameter int TBL_N  = 16,
  parameter int PEND_N = 8,
  parameter int OFS_W  = 16,
  parameter int ENG_W  = 4,
  parameter int DW     = 64,
  parameter int unsigned USER_BASE = 32'h4000
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             reg_valid_i,
  input  logic [OFS_W-1:0] reg_offset_i,
  input  logic [2:0]       reg_type_i,
  input  logic [ENG_W-1:0] reg_engine_i,
  input  logic             clear_user_i,
  input  logic             wr_valid_i,
  input  logic [OFS_W-1:0] wr_offset_i,
  input  logic [DW-1:0]    wr_data_i,
  output logic             wr_ready_o,
  input  logic             replay_valid_i,
  input  logic [OFS_W-1:0] replay_offset_i,
  output logic             disp_valid_o,
  output logic [2:0]       disp_type_o,
  output logic [ENG_W-1:0] disp_engine_o,
  output logic [OFS_W-1:0] disp_offset_o,
  output logic [DW-1:0]    disp_data_o,
  output logic             aql_idx_valid_o,
  output logic [DW-1:0]    aql_idx_o,
  output logic             err_o,
  output logic             pend_ovf_o
);
  localparam int HALF = DW / 2;

  logic             wr_take, rp_hit, src_valid, go, bad;
  logic [OFS_W-1:0] src_ofs;
  logic [DW-1:0]    src_data, pend_data, shaped, plus1;
  logic             tbl_hit;
  logic [2:0]       tbl_ty;
  logic [ENG_W-1:0] tbl_eng;
  qtype_e           qt;

  // replay owns the single dispatch slot
  assign wr_ready_o = !replay_valid_i;
  assign wr_take    = wr_valid_i && wr_ready_o;

  db_pend #(.N(PEND_N), .OFS_W(OFS_W), .DW(DW)) i_pend (
    .clk_i, .rst_ni,
    .store_i      (wr_take && !tbl_hit),
    .store_ofs_i  (wr_offset_i),
    .store_data_i (wr_data_i),
    .look_ofs_i   (replay_offset_i),
    .free_i       (rp_hit && tbl_hit),
    .hit_o        (rp_hit_raw),
    .data_o       (pend_data),
    .ovf_o        (pend_ovf_o)
  );

  logic rp_hit_raw;
  assign rp_hit    = replay_valid_i && rp_hit_raw;
  assign src_valid = rp_hit || wr_take;
  assign src_ofs   = rp_hit ? replay_offset_i : wr_offset_i;
  assign src_data  = rp_hit ? pend_data : wr_data_i;

  db_table #(.N(TBL_N), .OFS_W(OFS_W), .ENG_W(ENG_W), .USER_BASE(USER_BASE)) i_table (
    .clk_i, .rst_ni,
    .reg_i      (reg_valid_i),
    .reg_ofs_i  (reg_offset_i),
    .reg_type_i (reg_type_i),
    .reg_eng_i  (reg_engine_i),
    .clear_i    (clear_user_i),
    .look_ofs_i (src_ofs),
    .hit_o      (tbl_hit),
    .type_o     (tbl_ty),
    .eng_o      (tbl_eng)
  );

  assign qt    = qtype_e'(tbl_ty);
  assign go    = src_valid && tbl_hit;
  assign bad   = go && (qt == QT_BAD);
  assign plus1 = src_data + DW'(1);

  always_comb begin
    case (qt)
      QT_AQL:  shaped = plus1;
      QT_IRQ:  shaped = {{(DW-HALF){1'b0}}, src_data[HALF-1:0]};
      default: shaped = src_data;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      disp_valid_o    <= 1'b0;
      disp_type_o     <= '0;
      disp_engine_o   <= '0;
      disp_offset_o   <= '0;
      disp_data_o     <= '0;
      aql_idx_valid_o <= 1'b0;
      aql_idx_o       <= '0;
      err_o           <= 1'b0;
    end else begin
      disp_valid_o    <= go && !bad;
      aql_idx_valid_o <= go && (qt == QT_AQL);
      err_o           <= bad;
      if (go) begin
        disp_type_o   <= tbl_ty;
        disp_engine_o <= tbl_eng;
        disp_offset_o <= src_ofs;
        disp_data_o   <= shaped;
        aql_idx_o     <= plus1;
      end
    end
  end

  p_irq_low_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    disp_valid_o && (disp_type_o == 3'd5) |-> disp_data_o[DW-1:HALF] == '0);
  p_aql_pair_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    aql_idx_valid_o |-> disp_valid_o && (disp_type_o == 3'd4) && (aql_idx_o == disp_data_o));
  p_err_excl_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> !disp_valid_o);
  p_ovf_sticky_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pend_ovf_o |=> pend_ovf_o);
endmodule

// File: tb/test_doorbell_router.sv
module test_doorbell_router;
  localparam time CLK = 8ns;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        reg_valid_i = 1'b0;
  logic [15:0] reg_offset_i = '0;
  logic [2:0]  reg_type_i = '0;
  logic [3:0]  reg_engine_i = '0;
  logic        clear_user_i = 1'b0;
  logic        wr_valid_i = 1'b0;
  logic [15:0] wr_offset_i = '0;
  logic [63:0] wr_data_i = '0;
  logic        wr_ready_o;
  logic        replay_valid_i = 1'b0;
  logic [15:0] replay_offset_i = '0;
  logic        disp_valid_o;
  logic [2:0]  disp_type_o;
  logic [3:0]  disp_engine_o;
  logic [15:0] disp_offset_o;
  logic [63:0] disp_data_o;
  logic        aql_idx_valid_o;
  logic [63:0] aql_idx_o;
  logic        err_o;
  logic        pend_ovf_o;

  int checks = 0;
  int fails  = 0;

  always #(CLK/2) clk_i = ~clk_i;

  doorbell_router i_doorbell_router (.*);

  task automatic chk(input string r, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", r, act, exp);
    end
  endtask

  task automatic bind_q(input logic [15:0] o, input logic [2:0] t, input logic [3:0] e);
    reg_valid_i = 1'b1; reg_offset_i = o; reg_type_i = t; reg_engine_i = e;
    @(negedge clk_i);
    reg_valid_i = 1'b0;
  endtask

  task automatic ring(input logic [15:0] o, input logic [63:0] d);
    wr_valid_i = 1'b1; wr_offset_i = o; wr_data_i = d;
    #1 chk("R6 ready", wr_ready_o, 1);
    @(negedge clk_i);
    wr_valid_i = 1'b0;
  endtask

  task automatic replay(input logic [15:0] o);
    replay_valid_i = 1'b1; replay_offset_i = o;
    @(negedge clk_i);
    replay_valid_i = 1'b0;
  endtask

  task automatic exp_disp(input string r, input logic [2:0] t, input logic [3:0] e,
                          input logic [15:0] o, input logic [63:0] d);
    chk({r, " valid"}, disp_valid_o, 1);
    chk({r, " type"}, disp_type_o, t);
    chk({r, " engine"}, disp_engine_o, e);
    chk({r, " offset"}, disp_offset_o, o);
    chk({r, " data"}, disp_data_o, d);
  endtask

  task automatic exp_none(input string r);
    chk({r, " no dispatch"}, disp_valid_o, 0);
    chk({r, " no error"}, err_o, 0);
  endtask

  initial begin
    #(CLK * 100000);
    fails++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [63:0] d, e;
    repeat (2) @(negedge clk_i);
    // R1
    chk("R1 disp", disp_valid_o, 0);
    chk("R1 aql", aql_idx_valid_o, 0);
    chk("R1 err", err_o, 0);
    chk("R1 ovf", pend_ovf_o, 0);
    chk("R1 ready", wr_ready_o, 1);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R2 R3 R4: sweep all defined classes
    for (int t = 0; t < 7; t++) bind_q(16'h0100 + 16'(t), 3'(t), 4'(t + 3));
    for (int t = 0; t < 7; t++) begin
      d = 64'hA5A5_0000_1234_5670 + 64'(t) * 64'h0001_0000_0001_0001;
      e = (t == 4) ? d + 1 : (t == 5) ? {32'h0, d[31:0]} : d;
      ring(16'h0100 + 16'(t), d);
      exp_disp((t == 5) ? "R3" : (t == 4) ? "R4" : "R2", 3'(t), 4'(t + 3), 16'h0100 + 16'(t), e);
      chk("R4 idx valid", aql_idx_valid_o, (t == 4) ? 1 : 0);
      if (t == 4) chk("R4 idx", aql_idx_o, e);
      @(negedge clk_i);
      chk("R2 one pulse", disp_valid_o, 0);
    end
    ring(16'h0104, 64'hFFFF_FFFF_FFFF_FFFF);
    exp_disp("R4 wrap", 3'd4, 4'd7, 16'h0104, 64'h0);
    chk("R4 wrap idx", aql_idx_o, 64'h0);

    // R10
    bind_q(16'h01F0, 3'd7, 4'd1);
    ring(16'h01F0, 64'h55);
    chk("R10 err", err_o, 1);
    chk("R10 no dispatch", disp_valid_o, 0);
    @(negedge clk_i);
    chk("R10 err pulse", err_o, 0);

    // R5
    bind_q(16'h0100, 3'd3, 4'd9);
    ring(16'h0100, 64'h77);
    exp_disp("R5", 3'd3, 4'd9, 16'h0100, 64'h77);

    // R6 R13 R7
    ring(16'h4500, 64'hAAAA);
    exp_none("R6 miss");
    ring(16'h4500, 64'hBBBB);
    exp_none("R6 miss2");
    replay(16'h4500);
    exp_none("R13 unbound replay");
    bind_q(16'h4500, 3'd0, 4'd2);
    replay(16'h4500);
    exp_disp("R7 replay", 3'd0, 4'd2, 16'h4500, 64'hBBBB);
    replay(16'h4500);
    exp_none("R7 freed");
    replay(16'h7777);
    exp_none("R7 absent");

    // R8
    ring(16'h4600, 64'hC0C0);
    bind_q(16'h4600, 3'd1, 4'd5);
    replay_valid_i = 1'b1; replay_offset_i = 16'h4600;
    wr_valid_i = 1'b1; wr_offset_i = 16'h0101; wr_data_i = 64'hD0D0;
    #1 chk("R8 stall", wr_ready_o, 0);
    @(negedge clk_i);
    replay_valid_i = 1'b0;
    exp_disp("R8 replay first", 3'd1, 4'd5, 16'h4600, 64'hC0C0);
    #1 chk("R8 ready back", wr_ready_o, 1);
    @(negedge clk_i);
    wr_valid_i = 1'b0;
    exp_disp("R8 write later", 3'd1, 4'd4, 16'h0101, 64'hD0D0);

    // R9
    bind_q(16'h3FFF, 3'd2, 4'd1);
    bind_q(16'h4000, 3'd2, 4'd1);
    clear_user_i = 1'b1;
    @(negedge clk_i);
    clear_user_i = 1'b0;
    ring(16'h4500, 64'h1);
    exp_none("R9 removed 4500");
    ring(16'h4000, 64'h2);
    exp_none("R9 removed 4000");
    ring(16'h3FFF, 64'h3);
    exp_disp("R9 kept 3FFF", 3'd2, 4'd1, 16'h3FFF, 64'h3);
    ring(16'h0102, 64'h4);
    exp_disp("R9 kept low", 3'd2, 4'd5, 16'h0102, 64'h4);

    // R11: two parked, fill six more
    for (int i = 0; i < 6; i++) ring(16'h5000 + 16'(i), 64'(i) + 64'h900);
    chk("R11 not yet", pend_ovf_o, 0);
    ring(16'h5100, 64'hE0);
    chk("R11 ovf", pend_ovf_o, 1);
    bind_q(16'h5100, 3'd0, 4'd0);
    replay(16'h5100);
    exp_none("R11 discarded");
    bind_q(16'h5000, 3'd6, 4'd8);
    replay(16'h5000);
    exp_disp("R11 kept entry", 3'd6, 4'd8, 16'h5000, 64'h900);
    repeat (3) @(negedge clk_i);
    chk("R11 sticky", pend_ovf_o, 1);

    // R12: 11 bound, add 5 to fill, then one more
    for (int i = 0; i < 5; i++) bind_q(16'h0200 + 16'(i), 3'd0, 4'(i));
    bind_q(16'h0300, 3'd1, 4'd1);
    ring(16'h0300, 64'h31);
    exp_none("R12 dropped");
    ring(16'h0204, 64'h32);
    exp_disp("R12 last fits", 3'd0, 4'd4, 16'h0204, 64'h32);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule